// File: doc/BRIEF.md
# Cartridge bank-switch and mirroring controller

This block is the memory-mapping controller of an 8-bit console cartridge. The CPU writes bank numbers into a small register file: eight character-bank registers, one program-bank register and a mirroring register. The block then turns every CPU and PPU address into a ROM address and picks the nametable page for the console's video RAM. The program space is split into a switchable 16 KiB lower half and an upper half that is always the last 16 KiB bank. The pattern space is split into eight 1 KiB windows, and each window has its own bank.

A strap input picks one of two register decode windows. The low window takes writes in CPU `$6000-$7FFF` and compares the address under mask `$E00F`. The high window takes writes in `$8000-$FFFF` under mask `$800F`. In both windows the low nibble of the address selects the register. Only the high window has a serial-memory pin register, which drives clock, data and read-direction pins. Only the high window returns the serial data line on CPU reads. Writes to the three timer offsets leave the block as one-cycle strobes together with the write data, for a separate timer block.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, every character and program bank register reads as zero, mirroring is vertical, and the serial clock, data and read-enable pins are all 0.
- R2: With `win_sel_i`=0, a write is taken only when CPU address bits 15:13 equal 3'b011. Address bits 12:4 are ignored, so `$7FF0` reaches the same register as `$6000`.
- R3: With `win_sel_i`=1, a write is taken only when CPU address bit 15 is 1, so `$FFF8` reaches the program bank register. Writes outside the selected window change no register.
- R4: Register offsets 0-7 (address bits 3:0) load character bank 0-7 from the data byte. For PPU addresses `$0000-$1FFF`, `chr_addr_o` = {bank[ppu_addr_i[12:10]], ppu_addr_i[9:0]}.
- R5: For CPU addresses `$8000-$BFFF`, `prg_addr_o` = {program bank, cpu_addr_i[13:0]}. For `$C000-$FFFF` the bank field is always PRG_BANKS-1.
- R6: Register offset 9 sets the mirroring mode from data bits 1:0. The page output is ppu_addr_i[10] in mode 0 (vertical), ppu_addr_i[11] in mode 1 (horizontal), 0 in mode 2 and 1 in mode 3.
- R7: In the high window only, a write to offset `$D` sets the serial clock from data bit 5, serial data from bit 6 and read-enable from bit 7. A write to offset `$D` in the low window leaves all three pins unchanged.
- R8: With `win_sel_i`=1 and `cpu_rd_i`=1 at an address in `$6000-$7FFF`, `cpu_data_oe_o`=8'h10 and `cpu_data_o` carries `ser_din_i` on bit 4. Every other bit is undriven. In all other cases `cpu_data_oe_o` and `cpu_data_o` are both zero.
- R9: An accepted write to offset `$A`, `$B` or `$C` raises bit 0, 1 or 2 of `tmr_wr_o` in that same cycle, with `tmr_data_o` equal to the write data. All other writes leave `tmr_wr_o` at zero.
- R10: The program bank register keeps only data bits 3:0 and the mirroring register only bits 1:0. Higher data bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_sel_i | input | 1 | Decode window strap: 0 low window, 1 high window |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_wr_i | input | 1 | CPU write strobe, one cycle per write |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_data_o | output | 8 | CPU read data |
| cpu_data_oe_o | output | 8 | Per-bit drive enable for the read data |
| prg_addr_o | output | PRG_AW | Program ROM address |
| ppu_addr_i | input | 14 | PPU address |
| chr_addr_o | output | CHR_AW | Character ROM address |
| nt_page_o | output | 1 | Nametable page select |
| ser_scl_o | output | 1 | Serial-memory clock pin |
| ser_sda_o | output | 1 | Serial-memory data pin |
| ser_rd_en_o | output | 1 | Serial-memory read-direction enable |
| ser_din_i | input | 1 | Serial-memory data returned to the CPU |
| tmr_wr_o | output | 3 | Timer register write strobes for offsets $A, $B, $C |
| tmr_data_o | output | 8 | Write data forwarded to the timer |

## Verification
The bench aims at the decode window. It writes through addresses that alias under one mask but fall outside the other window. A decoder that compared too few address bits would change a bank when it should not. One that compared too many would miss the `$7FF0` and `$FFF8` aliases. It writes out-of-range high bits to the program and mirroring registers, and a register that kept them would show a wrong bank or page. It also writes offset `$D` and reads `$6000` in both windows. A design that did not gate the serial path on the strap would move the pins or drive the data bus in the low window.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

   localparam int CHR_WIN = 8;

   localparam logic [3:0] OFS_PRG   = 4'h8;
   localparam logic [3:0] OFS_MIR   = 4'h9;
   localparam logic [3:0] OFS_TMR_A = 4'hA;
   localparam logic [3:0] OFS_TMR_B = 4'hB;
   localparam logic [3:0] OFS_TMR_C = 4'hC;
   localparam logic [3:0] OFS_SER   = 4'hD;

   typedef enum logic [1:0] {
      MIR_VERT   = 2'd0,
      MIR_HORZ   = 2'd1,
      MIR_ONE_LO = 2'd2,
      MIR_ONE_HI = 2'd3
   } mirror_e;

   typedef struct packed {
      logic       chr_we;
      logic [2:0] chr_idx;
      logic       prg_we;
      logic       mir_we;
      logic       ser_we;
      logic [2:0] tmr_we;
   } wr_cmd_t;

endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
   import cbc_pkg::*;
(
   input  logic        win_sel_i,
   input  logic [15:0] cpu_addr_i,
   input  logic        cpu_wr_i,
   input  logic        cpu_rd_i,
   output wr_cmd_t     cmd_o,
   output logic        ser_rd_hit_o
);

   logic       lo_win;
   logic       hi_win;
   logic       wr_hit;
   logic [3:0] ofs;
   logic [8:0] unused_mid_bits;

   assign lo_win = (cpu_addr_i[15:13] == 3'b011);
   assign hi_win = cpu_addr_i[15];
   assign wr_hit = cpu_wr_i & (win_sel_i ? hi_win : lo_win);
   assign ofs    = cpu_addr_i[3:0];
   assign unused_mid_bits = cpu_addr_i[12:4];

   always_comb begin
      cmd_o         = '0;
      cmd_o.chr_idx = ofs[2:0];
      if (wr_hit) begin
         cmd_o.chr_we    = ~ofs[3];
         cmd_o.prg_we    = (ofs == OFS_PRG);
         cmd_o.mir_we    = (ofs == OFS_MIR);
         cmd_o.ser_we    = win_sel_i & (ofs == OFS_SER);
         cmd_o.tmr_we[0] = (ofs == OFS_TMR_A);
         cmd_o.tmr_we[1] = (ofs == OFS_TMR_B);
         cmd_o.tmr_we[2] = (ofs == OFS_TMR_C);
      end
   end

   assign ser_rd_hit_o = cpu_rd_i & win_sel_i & lo_win;

endmodule

// File: rtl/cbc_regs.sv
module cbc_regs
   import cbc_pkg::*;
#(
   parameter int CHR_BW    = 8,
   parameter int PRG_BW    = 4,
   parameter bit SERIAL_EN = 1'b1
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  wr_cmd_t                        cmd_i,
   input  logic [7:0]                     wdata_i,
   output logic [CHR_WIN-1:0][CHR_BW-1:0] chr_bank_o,
   output logic [PRG_BW-1:0]              prg_bank_o,
   output mirror_e                        mirror_o,
   output logic [2:0]                     ser_pins_o
);

   for (genvar w = 0; w < CHR_WIN; w++) begin : g_chr
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            chr_bank_o[w] <= '0;
         end else if (cmd_i.chr_we && (cmd_i.chr_idx == 3'(w))) begin
            chr_bank_o[w] <= wdata_i[CHR_BW-1:0];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prg_bank_o <= '0;
      end else if (cmd_i.prg_we) begin
         prg_bank_o <= wdata_i[PRG_BW-1:0];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mirror_o <= MIR_VERT;
      end else if (cmd_i.mir_we) begin
         mirror_o <= mirror_e'(wdata_i[1:0]);
      end
   end

   if (SERIAL_EN) begin : g_ser
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            ser_pins_o <= '0;
         end else if (cmd_i.ser_we) begin
            ser_pins_o <= wdata_i[7:5];
         end
      end
   end else begin : g_no_ser
      logic unused_ser_we;
      assign unused_ser_we = cmd_i.ser_we;
      assign ser_pins_o    = '0;
   end

endmodule

// File: rtl/cbc_xlat.sv
module cbc_xlat
   import cbc_pkg::*;
#(
   parameter int PRG_BANKS = 16,
   parameter int CHR_BW    = 8,
   parameter int PRG_BW    = 4,
   localparam int PRG_AW   = PRG_BW + 14,
   localparam int CHR_AW   = CHR_BW + 10
) (
   input  logic [CHR_WIN-1:0][CHR_BW-1:0] chr_bank_i,
   input  logic [PRG_BW-1:0]              prg_bank_i,
   input  mirror_e                        mirror_i,
   input  logic [15:0]                    cpu_addr_i,
   input  logic [13:0]                    ppu_addr_i,
   output logic [PRG_AW-1:0]              prg_addr_o,
   output logic [CHR_AW-1:0]              chr_addr_o,
   output logic                           nt_page_o
);

   localparam logic [PRG_BW-1:0] LAST_BANK = PRG_BW'(PRG_BANKS - 1);

   logic [PRG_BW-1:0] prg_sel;
   logic [2:0]        chr_win;
   logic [1:0]        unused_hi;

   assign unused_hi = {cpu_addr_i[15], ppu_addr_i[13]};

   assign prg_sel    = cpu_addr_i[14] ? LAST_BANK : prg_bank_i;
   assign prg_addr_o = {prg_sel, cpu_addr_i[13:0]};

   assign chr_win    = ppu_addr_i[12:10];
   assign chr_addr_o = {chr_bank_i[chr_win], ppu_addr_i[9:0]};

   always_comb begin
      unique case (mirror_i)
         MIR_VERT:   nt_page_o = ppu_addr_i[10];
         MIR_HORZ:   nt_page_o = ppu_addr_i[11];
         MIR_ONE_LO: nt_page_o = 1'b0;
         MIR_ONE_HI: nt_page_o = 1'b1;
         default:    nt_page_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
   import cbc_pkg::*;
#(
   parameter int PRG_BANKS = 16,
   parameter int CHR_BANKS = 256,
   parameter bit SERIAL_EN = 1'b1,
   localparam int PRG_BW   = $clog2(PRG_BANKS),
   localparam int CHR_BW   = $clog2(CHR_BANKS),
   localparam int PRG_AW   = PRG_BW + 14,
   localparam int CHR_AW   = CHR_BW + 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              win_sel_i,
   input  logic [15:0]       cpu_addr_i,
   input  logic [7:0]        cpu_data_i,
   input  logic              cpu_wr_i,
   input  logic              cpu_rd_i,
   output logic [7:0]        cpu_data_o,
   output logic [7:0]        cpu_data_oe_o,
   output logic [PRG_AW-1:0] prg_addr_o,
   input  logic [13:0]       ppu_addr_i,
   output logic [CHR_AW-1:0] chr_addr_o,
   output logic              nt_page_o,
   output logic              ser_scl_o,
   output logic              ser_sda_o,
   output logic              ser_rd_en_o,
   input  logic              ser_din_i,
   output logic [2:0]        tmr_wr_o,
   output logic [7:0]        tmr_data_o
);

   if (PRG_BANKS < 2 || PRG_BANKS > 16 || (1 << PRG_BW) != PRG_BANKS) begin : g_bad_prg
      $error("PRG_BANKS must be a power of two from 2 to 16");
   end
   if (CHR_BANKS < 2 || CHR_BANKS > 256 || (1 << CHR_BW) != CHR_BANKS) begin : g_bad_chr
      $error("CHR_BANKS must be a power of two from 2 to 256");
   end

   wr_cmd_t                        cmd;
   logic                           ser_rd_hit;
   logic [CHR_WIN-1:0][CHR_BW-1:0] chr_bank;
   logic [PRG_BW-1:0]              prg_bank;
   mirror_e                        mirror;
   logic [2:0]                     ser_pins;

   cbc_decode u_decode (
      .win_sel_i    (win_sel_i),
      .cpu_addr_i   (cpu_addr_i),
      .cpu_wr_i     (cpu_wr_i),
      .cpu_rd_i     (cpu_rd_i),
      .cmd_o        (cmd),
      .ser_rd_hit_o (ser_rd_hit)
   );

   cbc_regs #(
      .CHR_BW    (CHR_BW),
      .PRG_BW    (PRG_BW),
      .SERIAL_EN (SERIAL_EN)
   ) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cmd_i      (cmd),
      .wdata_i    (cpu_data_i),
      .chr_bank_o (chr_bank),
      .prg_bank_o (prg_bank),
      .mirror_o   (mirror),
      .ser_pins_o (ser_pins)
   );

   cbc_xlat #(
      .PRG_BANKS (PRG_BANKS),
      .CHR_BW    (CHR_BW),
      .PRG_BW    (PRG_BW)
   ) u_xlat (
      .chr_bank_i (chr_bank),
      .prg_bank_i (prg_bank),
      .mirror_i   (mirror),
      .cpu_addr_i (cpu_addr_i),
      .ppu_addr_i (ppu_addr_i),
      .prg_addr_o (prg_addr_o),
      .chr_addr_o (chr_addr_o),
      .nt_page_o  (nt_page_o)
   );

   assign ser_scl_o   = ser_pins[0];
   assign ser_sda_o   = ser_pins[1];
   assign ser_rd_en_o = ser_pins[2];

   if (SERIAL_EN) begin : g_rd
      assign cpu_data_oe_o = ser_rd_hit ? 8'h10 : 8'h00;
      assign cpu_data_o    = ser_rd_hit ? {3'b000, ser_din_i, 4'b0000} : 8'h00;
   end else begin : g_no_rd
      logic unused_rd;
      assign unused_rd     = ser_rd_hit ^ ser_din_i;
      assign cpu_data_oe_o = 8'h00;
      assign cpu_data_o    = 8'h00;
   end

   assign tmr_wr_o   = cmd.tmr_we;
   assign tmr_data_o = cpu_data_i;

endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
   parameter int PRG_BANKS = 16,
   parameter int PRG_AW    = 18
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              win_sel_i,
   input logic [15:0]       cpu_addr_i,
   input logic              cpu_wr_i,
   input logic              cpu_rd_i,
   input logic [7:0]        cpu_data_oe_o,
   input logic [PRG_AW-1:0] prg_addr_o,
   input logic              ser_scl_o,
   input logic              ser_sda_o,
   input logic              ser_rd_en_o,
   input logic [2:0]        tmr_wr_o
);

   logic [2:0] pins;
   logic       ser_wr;
   assign pins   = {ser_rd_en_o, ser_sda_o, ser_scl_o};
   assign ser_wr = cpu_wr_i && win_sel_i && cpu_addr_i[15] && (cpu_addr_i[3:0] == 4'hD);

   AST_TMR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(tmr_wr_o)); // R9

   AST_TMR_NEEDS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tmr_wr_o != 3'b000) |-> cpu_wr_i); // R9

   AST_FIXED_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_addr_i[15:14] == 2'b11) |-> (prg_addr_o[PRG_AW-1:14] == (PRG_AW-14)'(PRG_BANKS - 1))); // R5

   AST_SER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ser_wr |=> $stable(pins)); // R7

   AST_SER_LOW_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !win_sel_i |=> $stable(pins)); // R7

   AST_OE_ONLY_HI_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_data_oe_o != 8'h00) |-> (win_sel_i && cpu_rd_i)); // R8

   AST_OE_BIT4_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_data_oe_o & 8'hEF) == 8'h00); // R8

endmodule

bind cart_bank_ctrl cbc_checker #(
   .PRG_BANKS (PRG_BANKS),
   .PRG_AW    (PRG_AW)
) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .win_sel_i     (win_sel_i),
   .cpu_addr_i    (cpu_addr_i),
   .cpu_wr_i      (cpu_wr_i),
   .cpu_rd_i      (cpu_rd_i),
   .cpu_data_oe_o (cpu_data_oe_o),
   .prg_addr_o    (prg_addr_o),
   .ser_scl_o     (ser_scl_o),
   .ser_sda_o     (ser_sda_o),
   .ser_rd_en_o   (ser_rd_en_o),
   .tmr_wr_o      (tmr_wr_o)
);

// File: tb/tb_cart_bank_ctrl.sv
`timescale 1ns/1ps
module tb_cart_bank_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        win_sel = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_data = '0;
   logic        cpu_wr = 1'b0;
   logic        cpu_rd = 1'b0;
   logic [13:0] ppu_addr = '0;
   logic        ser_din = 1'b0;
   logic [7:0]  data_o, oe_o, tmr_data;
   logic [17:0] prg_addr, chr_addr;
   logic        page, scl, sda, rden;
   logic [2:0]  tmr_wr;

   always #2.5 clk = ~clk;

   cart_bank_ctrl dut (
      .clk_i(clk), .rst_ni(rst_n), .win_sel_i(win_sel),
      .cpu_addr_i(cpu_addr), .cpu_data_i(cpu_data), .cpu_wr_i(cpu_wr), .cpu_rd_i(cpu_rd),
      .cpu_data_o(data_o), .cpu_data_oe_o(oe_o), .prg_addr_o(prg_addr),
      .ppu_addr_i(ppu_addr), .chr_addr_o(chr_addr), .nt_page_o(page),
      .ser_scl_o(scl), .ser_sda_o(sda), .ser_rd_en_o(rden), .ser_din_i(ser_din),
      .tmr_wr_o(tmr_wr), .tmr_data_o(tmr_data)
   );

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [7:0] chr_m [8];
   logic [3:0] prg_m;
   logic [1:0] mir_m;
   logic [2:0] ser_m;

   // monitor: compares queued expectations away from the active edge
   always @(negedge clk) begin
      while (q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = q.pop_front();
         case (it.kind)
            0: act = {14'd0, chr_addr};
            1: act = {14'd0, prg_addr};
            2: act = {31'd0, page};
            3: act = {16'd0, oe_o, data_o};
            4: act = {29'd0, rden, sda, scl};
            default: act = {21'd0, tmr_wr, tmr_data};
         endcase
         total++;
         if (act !== it.exp) begin
            bad++;
            $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
         end
      end
   end

   task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
      logic       hit;
      logic [2:0] t;
      hit = win_sel ? a[15] : (a[15:13] == 3'b011);
      t = 3'b000;
      if (hit) begin
         case (a[3:0])
            4'hA: t = 3'b001;
            4'hB: t = 3'b010;
            4'hC: t = 3'b100;
            default: t = 3'b000;
         endcase
      end
      @(posedge clk); #1;
      cpu_addr = a; cpu_data = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
      q.push_back('{5, {21'd0, t, d}, tag});
      @(posedge clk); #1;
      cpu_wr = 1'b0;
      if (hit) begin
         if (!a[3]) chr_m[a[2:0]] = d;
         else if (a[3:0] == 4'h8) prg_m = d[3:0];
         else if (a[3:0] == 4'h9) mir_m = d[1:0];
         else if (a[3:0] == 4'hD && win_sel) ser_m = d[7:5];
      end
   endtask

   task automatic p_chr(input logic [13:0] pa, input string tag);
      @(posedge clk); #1;
      ppu_addr = pa;
      q.push_back('{0, {14'd0, chr_m[pa[12:10]], pa[9:0]}, tag});
   endtask

   task automatic p_prg(input logic [15:0] a, input string tag);
      logic [3:0] b;
      b = a[14] ? 4'hF : prg_m;
      @(posedge clk); #1;
      cpu_addr = a;
      q.push_back('{1, {14'd0, b, a[13:0]}, tag});
   endtask

   task automatic p_page(input logic [13:0] pa, input string tag);
      logic e;
      case (mir_m)
         2'd0: e = pa[10];
         2'd1: e = pa[11];
         2'd2: e = 1'b0;
         default: e = 1'b1;
      endcase
      @(posedge clk); #1;
      ppu_addr = pa;
      q.push_back('{2, {31'd0, e}, tag});
   endtask

   task automatic p_rd(input logic [15:0] a, input logic din, input string tag);
      logic [15:0] e;
      e = (win_sel && a[15:13] == 3'b011) ? {8'h10, 3'b000, din, 4'b0000} : 16'h0000;
      @(posedge clk); #1;
      cpu_addr = a; cpu_rd = 1'b1; ser_din = din;
      q.push_back('{3, {16'd0, e}, tag});
      @(posedge clk); #1;
      cpu_rd = 1'b0;
   endtask

   task automatic p_ser(input string tag);
      @(posedge clk); #1;
      q.push_back('{4, {29'd0, ser_m}, tag});
   endtask

   initial begin
      #500000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) chr_m[i] = 8'h00;
      prg_m = 4'h0; mir_m = 2'd0; ser_m = 3'b000;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < 8; i++) p_chr(14'(i * 1024 + 5), "R1");
      p_prg(16'h8123, "R1");
      p_page(14'h0400, "R1");
      p_ser("R1");

      // low window: R2, R4
      for (int i = 0; i < 8; i++) wr(16'h6000 + 16'(i), 8'(8'h13 + i * 8'h11), "R9");
      for (int i = 0; i < 8; i++) p_chr(14'(i * 1024 + 16'h2A7), "R4");
      wr(16'h7FF0, 8'hC4, "R2");
      p_chr(14'h0011, "R2");
      wr(16'h8001, 8'h99, "R3");
      p_chr(14'h0400, "R3");
      // R10 and R5
      wr(16'h6008, 8'hF5, "R10");
      p_prg(16'h8000, "R5");
      p_prg(16'hBFFF, "R5");
      p_prg(16'hC000, "R5");
      p_prg(16'hFFFF, "R5");
      // R6 mirroring modes
      wr(16'h6009, 8'h01, "R6");
      p_page(14'h0800, "R6");
      p_page(14'h0400, "R6");
      wr(16'h6009, 8'h02, "R6");
      p_page(14'h0C00, "R6");
      wr(16'h6009, 8'h03, "R6");
      p_page(14'h0000, "R6");
      wr(16'h6009, 8'hFC, "R10");
      p_page(14'h0400, "R10");
      p_page(14'h0800, "R10");
      // R7 low window ignores serial pins
      wr(16'h600D, 8'hE0, "R7");
      p_ser("R7");
      // R9 timer strobes in low window
      wr(16'h600A, 8'h5A, "R9");
      wr(16'h600B, 8'h3C, "R9");
      wr(16'h7FFC, 8'hA5, "R9");
      wr(16'h800A, 8'h77, "R9");
      // R8 low window never drives
      p_rd(16'h6000, 1'b1, "R8");

      // high window
      win_sel = 1'b1;
      wr(16'h8003, 8'hAB, "R3");
      p_chr(14'h0C44, "R3");
      wr(16'h6003, 8'h12, "R3");
      p_chr(14'h0C45, "R3");
      wr(16'hFFF8, 8'h07, "R3");
      p_prg(16'h8ABC, "R3");
      p_prg(16'hDABC, "R5");
      wr(16'h800D, 8'hE0, "R7");
      p_ser("R7");
      wr(16'h800D, 8'h20, "R7");
      p_ser("R7");
      wr(16'h600D, 8'hC0, "R7");
      p_ser("R7");
      p_rd(16'h6000, 1'b1, "R8");
      p_rd(16'h7ABC, 1'b0, "R8");
      p_rd(16'h8000, 1'b1, "R8");
      wr(16'h800C, 8'h81, "R9");
      wr(16'h600A, 8'h42, "R9");
      wr(16'h9009, 8'h01, "R6");
      p_page(14'h0800, "R6");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule